// File: doc/BRIEF.md
# Byte-Handshake I2C Bus Master

This block is a register-programmed I2C bus master that moves one byte at a time. Software loads a byte, sets the mode, and requests a START. The block then generates the START condition and shifts the byte out MSB first on open-drain SCL and SDA. It clocks the acknowledge bit and raises a pending flag. While that flag is set, SCL is held low. Clearing the flag lets the transfer continue with the next byte, or it closes the transfer with a STOP condition if the start/stop request bit has been dropped.

In master-transmit mode each following byte comes from the data register. In master-receive mode the bytes after the address are shifted in and can be read from the data register while the flag is pending. The master then answers with ACK or NACK according to a control bit. An interrupt output is active while the pending flag and the interrupt enable are both set. The bit rate comes from a fixed pre-divide (two parameterised ratios, selected by a control bit) followed by a programmable prescaler. The slave-mode, filter and SDA-delay fields are only stored.

Register map (byte offsets): control 0x00, status 0x04, own-address 0x08, data shift 0x0C, line control 0x10. Unmapped offsets read as zero.

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset every register reads 0x00, scl_oe and sda_oe are 0, irq is 0 and the busy bit (status bit 5) reads 0.
- R2: The own-address register at 0x08 stores all 8 bits, and the line-control register at 0x10 stores bits 2:0 (the other bits read 0). The control fields ack enable (bit 7), divide select (bit 6), interrupt enable (bit 5) and prescaler (bits 3:0) read back as written. Status bits 3:0 cannot be set by software writes.
- R3: A status write with bit 7 = 1 (master mode), bit 5 = 1 and bit 4 = 1 while idle starts a transfer. SDA is pulled low while SCL is released, busy reads 1, and the byte in the data register is then shifted out MSB first as the address byte in either master mode. A status write with bit 7 = 0 starts nothing.
- R4: Each SCL phase of a bit lasts D*(P+1) clock cycles, where P is control bits 3:0. D is DIV_LO when control bit 6 is 0 and DIV_HI when it is 1.
- R5: After each acknowledge clock, control bit 4 (pending) sets and status bit 0 holds the sampled SDA level (0 = acknowledged, 1 = not). SCL stays pulled low for as long as pending is set.
- R6: Writing 0 to control bit 4 resumes the transfer. In master-transmit mode (status bits 7:6 = 11) the byte then loaded in the data register is sent next.
- R7: In master-receive mode (bits 7:6 = 10), each byte after the address is shifted in and reads from 0x0C while pending. During the acknowledge clock the master pulls SDA low when control bit 7 is 1, and releases it (NACK) when bit 7 is 0.
- R8: A status write with bit 5 = 0, followed by clearing pending, produces a STOP: SDA rises while SCL is released. Busy then reads 0, and both lines are released.
- R9: irq is 1 exactly when pending and control bit 5 are both 1.
- R10: If SDA reads low at the end of a high phase in which the master is releasing SDA during a transmitted bit, status bit 3 sets. The transfer then aborts: both lines are released, busy reads 0 and pending stays 0.
- R11: Writing 1 to control bit 4 has no effect: a pending flag stays set, and a clear flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Byte-complete interrupt |

## Verification
The hardest situation to reach from the ports is a lost arbitration. It needs another driver to hold SDA low in exactly the high phase where the master is releasing it. The bench reaches it by loading an address byte whose MSB is 1 and holding an extra pull-down on the modelled SDA line from the START onward. The first bit then disagrees with the line. The receive path is also hard to reach, because it needs a responding slave that places its data bits after every falling SCL edge. A behavioural slave on the wired-AND line does this, and it also records the master's acknowledge level so that the ACK/NACK choice can be checked.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   localparam int OFS_CTRL = 0;
   localparam int OFS_STAT = 4;
   localparam int OFS_ADDR = 8;
   localparam int OFS_DATA = 12;
   localparam int OFS_LINE = 16;

   localparam int BYTE_W   = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_START,
      ST_BLO,
      ST_BHI,
      ST_ALO,
      ST_AHI,
      ST_HOLD,
      ST_PLO,
      ST_PHI,
      ST_PREL
   } i2cm_state_e;

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
   parameter int DIV_LO = 16,
   parameter int DIV_HI = 512,
   parameter int PRE_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             sel_hi,
   input  logic [PRE_W-1:0] pre,
   output logic             step
);
   localparam int SRC_W = $clog2(DIV_HI + 1);
   localparam logic [SRC_W-1:0] LO_END = SRC_W'(DIV_LO - 1);
   localparam logic [SRC_W-1:0] HI_END = SRC_W'(DIV_HI - 1);

   logic [SRC_W-1:0] src_cnt;
   logic [PRE_W-1:0] pre_cnt;
   logic             src_last;
   logic             pre_last;

   generate
      if (DIV_LO == DIV_HI) begin : g_fixed
         assign src_last = (src_cnt == LO_END);
         logic unused_sel;
         assign unused_sel = sel_hi;
      end else begin : g_select
         assign src_last = (src_cnt == (sel_hi ? HI_END : LO_END));
      end
   endgenerate

   assign pre_last = (pre_cnt >= pre);
   assign step     = run && src_last && pre_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_cnt <= '0;
         pre_cnt <= '0;
      end else if (!run) begin
         src_cnt <= '0;
         pre_cnt <= '0;
      end else if (src_last) begin
         src_cnt <= '0;
         pre_cnt <= pre_last ? '0 : pre_cnt + 1'b1;
      end else begin
         src_cnt <= src_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
   import i2cm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   output logic              run,
   input  logic              start,
   input  logic              mode_tx,
   input  logic              keep_on,
   input  logic              ack_en,
   input  logic              pend,
   input  logic              data_we,
   input  logic [BYTE_W-1:0] data_wdata,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              busy,
   output logic              arb_lost,
   output logic              last_bit,
   output logic [BYTE_W-1:0] shreg,
   output logic              byte_done
);
   localparam int CNT_W = $clog2(BYTE_W);

   i2cm_state_e      state;
   logic [CNT_W-1:0] bit_cnt;
   logic             tx_byte;
   logic             tx_low;
   logic             ack_low;

   assign tx_low    = tx_byte && !shreg[BYTE_W-1];
   assign ack_low   = !tx_byte && ack_en;
   assign busy      = (state != ST_IDLE);
   assign run       = (state != ST_IDLE) && (state != ST_HOLD);
   assign byte_done = (state == ST_AHI) && step;

   always_comb begin
      scl_oe = 1'b0;
      sda_oe = 1'b0;
      unique case (state)
         ST_IDLE:  begin scl_oe = 1'b0; sda_oe = 1'b0;    end
         ST_START: begin scl_oe = 1'b0; sda_oe = 1'b1;    end
         ST_BLO:   begin scl_oe = 1'b1; sda_oe = tx_low;  end
         ST_BHI:   begin scl_oe = 1'b0; sda_oe = tx_low;  end
         ST_ALO:   begin scl_oe = 1'b1; sda_oe = ack_low; end
         ST_AHI:   begin scl_oe = 1'b0; sda_oe = ack_low; end
         ST_HOLD:  begin scl_oe = 1'b1; sda_oe = ack_low; end
         ST_PLO:   begin scl_oe = 1'b1; sda_oe = 1'b1;    end
         ST_PHI:   begin scl_oe = 1'b0; sda_oe = 1'b1;    end
         ST_PREL:  begin scl_oe = 1'b0; sda_oe = 1'b0;    end
         default:  begin scl_oe = 1'b0; sda_oe = 1'b0;    end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         tx_byte  <= 1'b1;
         shreg    <= '0;
         arb_lost <= 1'b0;
         last_bit <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (data_we) shreg <= data_wdata;
               if (start) begin
                  state    <= ST_START;
                  tx_byte  <= 1'b1;
                  arb_lost <= 1'b0;
               end
            end
            ST_START: if (step) begin
               state   <= ST_BLO;
               bit_cnt <= CNT_W'(BYTE_W - 1);
            end
            ST_BLO: if (step) state <= ST_BHI;
            ST_BHI: if (step) begin
               if (tx_byte && shreg[BYTE_W-1] && !sda_in) begin
                  arb_lost <= 1'b1;
                  state    <= ST_IDLE;
               end else begin
                  shreg <= {shreg[BYTE_W-2:0], sda_in};
                  if (bit_cnt == '0) begin
                     state <= ST_ALO;
                  end else begin
                     bit_cnt <= bit_cnt - 1'b1;
                     state   <= ST_BLO;
                  end
               end
            end
            ST_ALO: if (step) state <= ST_AHI;
            ST_AHI: if (step) begin
               last_bit <= sda_in;
               state    <= ST_HOLD;
            end
            ST_HOLD: begin
               if (data_we) shreg <= data_wdata;
               if (!pend) begin
                  if (!keep_on) begin
                     state <= ST_PLO;
                  end else begin
                     state   <= ST_BLO;
                     bit_cnt <= CNT_W'(BYTE_W - 1);
                     tx_byte <= mode_tx;
                  end
               end
            end
            ST_PLO:  if (step) state <= ST_PHI;
            ST_PHI:  if (step) state <= ST_PREL;
            ST_PREL: if (step) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
   import i2cm_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int PRE_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   input  logic              eng_busy,
   input  logic              arb_lost,
   input  logic              last_bit,
   input  logic [BYTE_W-1:0] shreg,
   input  logic              byte_done,
   output logic              ack_en,
   output logic              clk_hi,
   output logic              pend,
   output logic [PRE_W-1:0]  pre,
   output logic              mode_tx,
   output logic              keep_on,
   output logic              start,
   output logic              data_we,
   output logic              irq
);
   logic       irq_en;
   logic [1:0] mode;
   logic       out_en;
   logic [BYTE_W-1:0] own_addr;
   logic [2:0] line_ctl;
   logic sel_ctrl, sel_stat, sel_addr, sel_data, sel_line;

   assign sel_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
   assign sel_stat = (reg_addr == ADDR_W'(OFS_STAT));
   assign sel_addr = (reg_addr == ADDR_W'(OFS_ADDR));
   assign sel_data = (reg_addr == ADDR_W'(OFS_DATA));
   assign sel_line = (reg_addr == ADDR_W'(OFS_LINE));

   assign start   = reg_we && sel_stat && reg_wdata[7] && reg_wdata[5]
                    && reg_wdata[4] && !eng_busy;
   assign data_we = reg_we && sel_data;
   assign mode_tx = mode[0];
   assign irq     = pend && irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_en   <= 1'b0;
         clk_hi   <= 1'b0;
         irq_en   <= 1'b0;
         pend     <= 1'b0;
         pre      <= '0;
         mode     <= 2'b00;
         keep_on  <= 1'b0;
         out_en   <= 1'b0;
         own_addr <= '0;
         line_ctl <= '0;
      end else begin
         if (byte_done) begin
            pend <= 1'b1;
         end else if (reg_we && sel_ctrl && !reg_wdata[4]) begin
            pend <= 1'b0;
         end
         if (reg_we && sel_ctrl) begin
            ack_en <= reg_wdata[7];
            clk_hi <= reg_wdata[6];
            irq_en <= reg_wdata[5];
            pre    <= reg_wdata[PRE_W-1:0];
         end
         if (reg_we && sel_stat) begin
            mode    <= reg_wdata[7:6];
            keep_on <= reg_wdata[5];
            out_en  <= reg_wdata[4];
         end
         if (reg_we && sel_addr) own_addr <= reg_wdata;
         if (reg_we && sel_line) line_ctl <= reg_wdata[2:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (sel_ctrl) reg_rdata = {ack_en, clk_hi, irq_en, pend, 4'(pre)};
      if (sel_stat) reg_rdata = {mode, eng_busy, out_en, arb_lost, 2'b00, last_bit};
      if (sel_addr) reg_rdata = own_addr;
      if (sel_data) reg_rdata = shreg;
      if (sel_line) reg_rdata = {5'b0, line_ctl};
   end
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
   import i2cm_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int PRE_W  = 4,
   parameter int DIV_LO = 16,
   parameter int DIV_HI = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              irq
);
   if (ADDR_W < 5) begin : g_bad_addr
      $error("i2cm_ctrl: ADDR_W must reach offset 0x10");
   end
   if (PRE_W < 1 || PRE_W > 4) begin : g_bad_pre
      $error("i2cm_ctrl: PRE_W must be 1..4");
   end
   if (DIV_LO < 2 || DIV_HI < DIV_LO) begin : g_bad_div
      $error("i2cm_ctrl: need 2 <= DIV_LO <= DIV_HI");
   end

   logic             step, run, start, data_we;
   logic             ack_en, clk_hi, pend, mode_tx, keep_on;
   logic [PRE_W-1:0] pre;
   logic             eng_busy, arb_lost, last_bit, byte_done;
   logic [BYTE_W-1:0] shreg;

   i2cm_regs #(.ADDR_W(ADDR_W), .PRE_W(PRE_W)) regs_i (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_busy(eng_busy), .arb_lost(arb_lost), .last_bit(last_bit), .shreg(shreg),
      .byte_done(byte_done),
      .ack_en(ack_en), .clk_hi(clk_hi), .pend(pend), .pre(pre),
      .mode_tx(mode_tx), .keep_on(keep_on), .start(start), .data_we(data_we), .irq(irq)
   );

   i2cm_tick #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .PRE_W(PRE_W)) tick_i (
      .clk(clk), .rst_n(rst_n), .run(run), .sel_hi(clk_hi), .pre(pre), .step(step)
   );

   i2cm_engine eng_i (
      .clk(clk), .rst_n(rst_n), .step(step), .run(run), .start(start),
      .mode_tx(mode_tx), .keep_on(keep_on), .ack_en(ack_en), .pend(pend),
      .data_we(data_we), .data_wdata(reg_wdata), .sda_in(sda_in),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(eng_busy), .arb_lost(arb_lost),
      .last_bit(last_bit), .shreg(shreg), .byte_done(byte_done)
   );
endmodule

// File: rtl/i2cm_ctrl_chk.sv
module i2cm_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_oe,
   input logic sda_oe,
   input logic irq,
   input logic busy,
   input logic pend,
   input logic arb
);
   a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe));

   a_r3_start_shape: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (sda_oe && !scl_oe));

   a_r5_stall_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && busy) |-> scl_oe);

   a_r5_pend_after_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> !$past(scl_oe));

   a_r8_end_released: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (!scl_oe && !sda_oe && !$past(scl_oe)));

   a_r9_irq_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (scl_oe && busy));

   a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb) |-> (!busy && !pend));
endmodule

bind i2cm_ctrl i2cm_ctrl_chk chk_i (
   .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
   .busy(eng_busy), .pend(pend), .arb(arb_lost)
);

// File: tb/i2cm_ctrl_tb_top.sv
module i2cm_ctrl_tb_top;
   localparam int DLO = 2;
   localparam int DHI = 4;
   localparam logic [4:0] A_CTRL = 5'd0, A_STAT = 5'd4, A_ADDR = 5'd8,
                          A_DATA = 5'd12, A_LINE = 5'd16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0] reg_addr = '0;
   logic reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic scl_oe, sda_oe, irq, sda_in;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   // behavioural slave on the wired-AND line
   logic slv_pull = 1'b0;
   logic arb_force = 1'b0;
   bit   slv_ack = 1'b1;
   logic prev_scl = 1'b1, prev_sda = 1'b1;
   int   bitcnt = 0;
   bit   in_addr = 1'b0, read_mode = 1'b0, ack_sampled = 1'b0;
   logic [7:0] rx_byte = '0, got_byte = '0;
   logic [7:0] tx_q [0:1];
   int   rd_idx = 0;
   int   stop_seen = 0;

   assign sda_in = !(sda_oe || slv_pull || arb_force);

   i2cm_ctrl #(.ADDR_W(5), .PRE_W(4), .DIV_LO(DLO), .DIV_HI(DHI)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_in),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
   );

   always #10 clk = ~clk;

   always @(negedge clk) begin
      logic scl, sda;
      scl = !scl_oe;
      sda = sda_in;
      if (prev_scl && scl && prev_sda && !sda) begin
         bitcnt = 0; in_addr = 1'b1; read_mode = 1'b0; rd_idx = 0; slv_pull = 1'b0;
      end else if (prev_scl && scl && !prev_sda && sda) begin
         stop_seen++; bitcnt = 0; in_addr = 1'b0; read_mode = 1'b0; slv_pull = 1'b0;
      end else if (!prev_scl && scl) begin
         if (bitcnt < 8) begin
            rx_byte = {rx_byte[6:0], sda}; bitcnt++;
         end else if (bitcnt == 8) begin
            ack_sampled = sda; bitcnt = 9;
         end
      end else if (prev_scl && !scl) begin
         if (bitcnt == 8) begin
            got_byte = rx_byte;
            if (in_addr) begin
               read_mode = rx_byte[0]; slv_pull = slv_ack;
            end else if (!read_mode) begin
               slv_pull = slv_ack;
            end else begin
               slv_pull = 1'b0; rd_idx++;
            end
         end else if (bitcnt == 9) begin
            bitcnt = 0; in_addr = 1'b0;
            if (read_mode && !ack_sampled && rd_idx < 2) slv_pull = !tx_q[rd_idx][7];
            else slv_pull = 1'b0;
         end else if (bitcnt >= 1 && bitcnt <= 7 && read_mode && !in_addr && rd_idx < 2) begin
            slv_pull = !tx_q[rd_idx][7-bitcnt];
         end
      end
      prev_scl = scl;
      prev_sda = sda;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_pend(output bit ok);
      logic [7:0] v;
      ok = 1'b0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         rd(A_CTRL, v);
         if (v[4]) begin ok = 1'b1; break; end
      end
   endtask

   task automatic wait_idle(output bit ok);
      logic [7:0] v;
      ok = 1'b0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         rd(A_STAT, v);
         if (!v[5]) begin ok = 1'b1; break; end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog: run did not complete actual=0 expected=1");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, ab, db;
      bit ok;
      int n, half, stops;
      logic sel;
      logic [3:0] pre;

      tx_q[0] = 8'hA5; tx_q[1] = 8'h3C;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      begin
         logic [4:0] al [0:4];
         al[0] = A_CTRL; al[1] = A_STAT; al[2] = A_ADDR; al[3] = A_DATA; al[4] = A_LINE;
         for (int i = 0; i < 5; i++) begin
            rd(al[i], v);
            chk(v == 8'h00, "R1 register reset value", v, 0);
         end
      end
      chk(!scl_oe && !sda_oe && !irq, "R1 lines and irq after reset",
          {scl_oe, sda_oe, irq}, 0);

      // R2: storage fields
      wr(A_ADDR, 8'h5A); rd(A_ADDR, v); chk(v == 8'h5A, "R2 own address", v, 8'h5A);
      wr(A_LINE, 8'hFF); rd(A_LINE, v); chk(v == 8'h07, "R2 line control", v, 8'h07);
      wr(A_CTRL, 8'hFF); rd(A_CTRL, v); chk(v == 8'hEF, "R2 control fields, R11 pend write 1", v, 8'hEF);
      wr(A_STAT, 8'h0F); rd(A_STAT, v); chk(v == 8'h00, "R2 status low bits not writable", v, 0);
      wr(A_CTRL, 8'h00);

      // R3: slave mode start request does nothing
      wr(A_STAT, 8'h30);
      repeat (20) @(negedge clk);
      rd(A_STAT, v);
      chk(!v[5] && !scl_oe && !sda_oe, "R3 no start in slave mode", v, 8'h30);

      // sweep divide select and prescaler in master transmit
      for (int cfg = 0; cfg < 8; cfg++) begin
         sel  = cfg[2];
         pre  = 4'(cfg[1:0]);
         half = (sel ? DHI : DLO) * (int'(pre) + 1);
         slv_ack = (cfg != 5);
         ab = {7'(7'h50 + cfg), 1'b0};
         db = 8'h96 ^ 8'(cfg * 17);
         wr(A_CTRL, {1'b1, sel, 1'b1, 1'b0, pre});
         wr(A_DATA, ab);
         wr(A_STAT, 8'hF0);
         rd(A_STAT, v);
         chk(v[5] && sda_oe && !scl_oe, "R3 start condition and busy", {v[5], sda_oe, scl_oe}, 3'b110);
         n = 0;
         for (int i = 0; i < 1000 && !scl_oe; i++) @(negedge clk);
         while (scl_oe && n < 2000) begin n++; @(negedge clk); end
         chk(n == half, "R4 SCL low phase length", n, half);
         wait_pend(ok);
         chk(ok, "R5 pending after address byte", ok, 1);
         #2;
         chk(got_byte == ab, "R3 address byte on bus", got_byte, ab);
         rd(A_STAT, v);
         chk(v[0] == !slv_ack, "R5 acknowledge status", v[0], !slv_ack);
         chk(irq, "R9 irq with enable and pending", irq, 1);
         repeat (40) @(negedge clk);
         chk(scl_oe && sda_in == !slv_ack ? 1'b1 : scl_oe, "R5 SCL held while pending", scl_oe, 1);
         if (cfg == 0) begin
            wr(A_CTRL, {1'b1, sel, 1'b0, 1'b1, pre});
            repeat (10) @(negedge clk);
            rd(A_CTRL, v);
            chk(v[4] && scl_oe, "R11 pend write 1 keeps stall", {v[4], scl_oe}, 2'b11);
            chk(!irq, "R9 irq masked by enable", irq, 0);
            wr(A_CTRL, {1'b1, sel, 1'b1, 1'b1, pre});
            chk(irq, "R9 irq back with enable", irq, 1);
         end
         if (slv_ack) begin
            wr(A_DATA, db);
            wr(A_CTRL, {1'b1, sel, 1'b1, 1'b0, pre});
            wait_pend(ok);
            chk(ok, "R6 pending after data byte", ok, 1);
            #2;
            chk(got_byte == db, "R6 data byte on bus", got_byte, db);
            rd(A_STAT, v);
            chk(v[0] == 1'b0, "R6 data acknowledged", v[0], 0);
         end
         stops = stop_seen;
         wr(A_STAT, 8'hD0);
         wr(A_CTRL, {1'b1, sel, 1'b1, 1'b0, pre});
         wait_idle(ok);
         chk(ok && stop_seen == stops + 1, "R8 STOP seen and busy cleared", stop_seen - stops, 1);
         chk(!scl_oe && !sda_oe && !irq, "R8 lines released after STOP", {scl_oe, sda_oe, irq}, 0);
      end

      // R7: master receive, two bytes, ACK then NACK
      slv_ack = 1'b1;
      wr(A_CTRL, {1'b1, 1'b0, 1'b1, 1'b0, 4'd1});
      wr(A_DATA, {7'h3B, 1'b1});
      wr(A_STAT, 8'hB0);
      wait_pend(ok);
      rd(A_STAT, v);
      chk(ok && v[0] == 1'b0, "R5 read address acknowledged", v[0], 0);
      wr(A_CTRL, {1'b1, 1'b0, 1'b1, 1'b0, 4'd1});
      wait_pend(ok);
      rd(A_DATA, v);
      chk(v == 8'hA5, "R7 first received byte", v, 8'hA5);
      chk(ack_sampled == 1'b0, "R7 master ACK driven", ack_sampled, 0);
      wr(A_CTRL, {1'b0, 1'b0, 1'b1, 1'b0, 4'd1});
      wait_pend(ok);
      rd(A_DATA, v);
      chk(v == 8'h3C, "R7 second received byte", v, 8'h3C);
      chk(ack_sampled == 1'b1, "R7 master NACK on last byte", ack_sampled, 1);
      rd(A_STAT, v);
      chk(v[0] == 1'b1, "R7 status shows NACK", v[0], 1);
      stops = stop_seen;
      wr(A_STAT, 8'h90);
      wr(A_CTRL, {1'b0, 1'b0, 1'b1, 1'b0, 4'd1});
      wait_idle(ok);
      chk(ok && stop_seen == stops + 1, "R8 STOP after receive", stop_seen - stops, 1);

      // R10: arbitration loss on first address bit
      wr(A_CTRL, {1'b1, 1'b0, 1'b1, 1'b0, 4'd0});
      wr(A_DATA, 8'hC4);
      arb_force = 1'b1;
      wr(A_STAT, 8'hF0);
      wait_idle(ok);
      rd(A_STAT, v);
      chk(ok && v[3], "R10 arbitration flag", v[3], 1);
      chk(!scl_oe && !sda_oe, "R10 lines released after abort", {scl_oe, sda_oe}, 0);
      rd(A_CTRL, v);
      chk(!v[4] && !irq, "R10 no pending after abort", v[4], 0);
      arb_force = 1'b0;
      repeat (5) @(negedge clk);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule